// File: doc/BRIEF.md
# Host Interrupt Aggregation Controller

This block gathers single-cycle event pulses from device-side sources into a sticky pending vector and reports them to a host through a small register file on a simple bus. Each source has a fixed bit position: 0 receive buffer A, 1 transmit data, 2 transmit transfer, 3 receive buffer B, 4 receive transfer, 5 and 6 event mailbox, 7 wake, 8 and 9 debug trace, 10 command complete, 14 init complete, 16 coexistence sense enable, 17 coexistence sense disable. The remaining positions up to 17 are spare inputs that behave the same way.

A mask decides which pending bits may drive the host interrupt line. The host can write the mask directly, or change single bits without a read-modify-write through a set alias and a clear alias. Pending bits can be read without side effects, read and cleared in one access, or cleared selectively by an acknowledge write. A configuration register enables the line and selects its polarity.

Registers sit at word addresses on the 3-bit `addr_i`: 0 mask (read/write), 1 mask set (write-only), 2 mask clear (write-only), 3 status peek (read-only), 4 status take (read-only, clear on read), 5 acknowledge (write-only), 6 configuration (read/write, bit 0 line enable, bit 1 active-low).

Top module: `host_irq_agg`

## Requirements
- R1: After reset the mask reads 0x0000_0001, the configuration reads 0 and both status views read 0.
- R2: A write to address 0 loads mask bits 17:0 from write data; mask bits 31:18 always read 0.
- R3: A write to address 1 sets each mask bit whose write-data bit is 1 and leaves the others unchanged.
- R4: A write to address 2 clears each mask bit whose write-data bit is 1 and leaves the others unchanged.
- R5: A read of address 3 returns the pending vector in bits 17:0 (zero above) and leaves it unchanged.
- R6: A read of address 4 returns the pending vector and clears every pending bit on the same edge.
- R7: A write to address 5 clears each pending bit whose write-data bit is 1; bits written 0 stay pending.
- R8: An event pulse in the same cycle as a take read or an acknowledge of that bit leaves the bit pending.
- R9: `irq_o` equals (enable AND any pending bit with mask 0) XOR active-low, one cycle after the register state it reflects; with enable 0 it sits at the active-low value.
- R10: Read data appears on `rd_data_o` in the cycle after `rd_en_i`; reads of addresses 1, 2, 5 and 7 return 0.
- R11: Events latch into the pending vector whether or not their mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | SRC_W (18) | Per-source event pulses, one cycle each |
| addr_i | input | 3 | Register word address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W (32) | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | DATA_W (32) | Registered read data |
| irq_o | output | 1 | Host interrupt line, polarity per configuration |

## Verification
The assertions take for granted that all inputs are known and stable at the rising edge, and that a single address serves both strobes, so a read and a write in one cycle hit the same register. The take and acknowledge properties assume the other strobe is idle in that cycle. The bench drives every input on the falling edge and models the register state itself, including cycles where an event coincides with a take read or an acknowledge.

// File: rtl/hia_pkg.sv
// Shared definitions for the host interrupt aggregator: register word
// addresses and configuration bit positions.
package hia_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_MASK = 3'd0,
        A_MSET = 3'd1,
        A_MCLR = 3'd2,
        A_PEEK = 3'd3,
        A_TAKE = 3'd4,
        A_ACK  = 3'd5,
        A_CFG  = 3'd6
    } reg_addr_e;

    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_LOW_BIT = 1;
    localparam int CFG_W       = 2;
endpackage

// File: rtl/hia_ctrl_regs.sv
// Mask and configuration storage.
// Holds SRC_W mask bits (1 = blocked) and the two line-control bits.
// Assumes at most one of the write strobes is high in a cycle, which the
// top-level address decode guarantees.
module hia_ctrl_regs #(
    parameter int               SRC_W    = 18,
    parameter logic [SRC_W-1:0] MASK_RST = SRC_W'(1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_mask_i,
    input  logic             wr_set_i,
    input  logic             wr_clr_i,
    input  logic             wr_cfg_i,
    input  logic [SRC_W-1:0] bits_i,
    input  logic [1:0]       cfg_i,
    output logic [SRC_W-1:0] mask_q,
    output logic             out_en_q,
    output logic             act_low_q
);
    logic [SRC_W-1:0] mask_d;

    // Next mask value from whichever write form is active.
    always_comb begin
        mask_d = mask_q;
        if (wr_mask_i)     mask_d = bits_i;
        else if (wr_set_i) mask_d = mask_q | bits_i;
        else if (wr_clr_i) mask_d = mask_q & ~bits_i;
    end

    // Mask register with its reset pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= MASK_RST;
        else        mask_q <= mask_d;
    end

    // Line enable and polarity select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_en_q  <= 1'b0;
            act_low_q <= 1'b0;
        end else if (wr_cfg_i) begin
            out_en_q  <= cfg_i[hia_pkg::CFG_EN_BIT];
            act_low_q <= cfg_i[hia_pkg::CFG_LOW_BIT];
        end
    end
endmodule

// File: rtl/hia_pending.sv
// Sticky pending vector, one independent slice per source.
// A pulse sets its bit; a take clears all bits; an acknowledge clears the
// selected bits. A pulse wins over any clear in the same cycle.
// Assumes event inputs are synchronous to clk.
module hia_pending #(
    parameter int SRC_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] evt_i,
    input  logic             take_i,
    input  logic             ack_wr_i,
    input  logic [SRC_W-1:0] ack_bits_i,
    output logic [SRC_W-1:0] pend_o
);
    for (genvar b = 0; b < SRC_W; b++) begin : g_slice
        logic bit_q;
        logic clr_b;

        // Clear request for this slice from take or acknowledge.
        assign clr_b = take_i || (ack_wr_i && ack_bits_i[b]);

        // Set has priority so no event is dropped.
        always_ff @(posedge clk) begin
            if (!rst_n)        bit_q <= 1'b0;
            else if (evt_i[b]) bit_q <= 1'b1;
            else if (clr_b)    bit_q <= 1'b0;
        end

        assign pend_o[b] = bit_q;
    end
endmodule

// File: rtl/hia_irq_drive.sv
// Host line generator.
// Registers (enable AND any unmasked pending) XOR active-low so the pin
// is glitch-free. Assumes mask bit 1 means blocked.
module hia_irq_drive #(
    parameter int SRC_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] pend_i,
    input  logic [SRC_W-1:0] mask_i,
    input  logic             out_en_i,
    input  logic             act_low_i,
    output logic             irq_o
);
    logic live;

    // Any pending source that the mask lets through.
    assign live = |(pend_i & ~mask_i);

    // Output flop; reset value matches the reset polarity (active high).
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= (out_en_i && live) ^ act_low_i;
    end
endmodule

// File: rtl/host_irq_agg.sv
// Host interrupt aggregator top.
// Decodes the register bus, instantiates the mask/config store, pending
// vector and line driver, and returns read data one cycle after rd_en_i.
// Assumes SRC_W < DATA_W and one address shared by both strobes.
module host_irq_agg #(
    parameter int SRC_W  = 18,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SRC_W-1:0]          evt_i,
    input  logic [hia_pkg::ADDR_W-1:0] addr_i,
    input  logic                      wr_en_i,
    input  logic [DATA_W-1:0]         wdata_i,
    input  logic                      rd_en_i,
    output logic [DATA_W-1:0]         rd_data_o,
    output logic                      irq_o
);
    import hia_pkg::*;

    logic [SRC_W-1:0]  mask_q;
    logic [SRC_W-1:0]  pend_q;
    logic              out_en_q;
    logic              act_low_q;
    logic              wr_mask, wr_set, wr_clr, wr_cfg, wr_ack, take;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rd_data_q;
    logic              unused_hi;

    // Write and read strobe decode.
    assign wr_mask = wr_en_i && (addr_i == A_MASK);
    assign wr_set  = wr_en_i && (addr_i == A_MSET);
    assign wr_clr  = wr_en_i && (addr_i == A_MCLR);
    assign wr_cfg  = wr_en_i && (addr_i == A_CFG);
    assign wr_ack  = wr_en_i && (addr_i == A_ACK);
    assign take    = rd_en_i && (addr_i == A_TAKE);

    assign unused_hi = ^wdata_i[DATA_W-1:SRC_W];

    hia_ctrl_regs #(.SRC_W(SRC_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mask_i (wr_mask),
        .wr_set_i  (wr_set),
        .wr_clr_i  (wr_clr),
        .wr_cfg_i  (wr_cfg),
        .bits_i    (wdata_i[SRC_W-1:0]),
        .cfg_i     (wdata_i[1:0]),
        .mask_q    (mask_q),
        .out_en_q  (out_en_q),
        .act_low_q (act_low_q)
    );

    hia_pending #(.SRC_W(SRC_W)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .take_i     (take),
        .ack_wr_i   (wr_ack),
        .ack_bits_i (wdata_i[SRC_W-1:0]),
        .pend_o     (pend_q)
    );

    hia_irq_drive #(.SRC_W(SRC_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (pend_q),
        .mask_i    (mask_q),
        .out_en_i  (out_en_q),
        .act_low_i (act_low_q),
        .irq_o     (irq_o)
    );

    // Read source selection; write-only and spare addresses give zero.
    always_comb begin
        rd_mux = '0;
        case (addr_i)
            A_MASK: rd_mux = DATA_W'(mask_q);
            A_PEEK: rd_mux = DATA_W'(pend_q);
            A_TAKE: rd_mux = DATA_W'(pend_q);
            A_CFG:  rd_mux = DATA_W'({act_low_q, out_en_q});
            default: rd_mux = '0;
        endcase
    end

    // Read data register, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data_q <= '0;
        else if (rd_en_i) rd_data_q <= rd_mux;
    end

    assign rd_data_o = rd_data_q;
endmodule

// File: rtl/host_irq_agg_chk.sv
// Property checker for host_irq_agg, attached by bind.
// Assumes inputs are known at every rising edge.
module host_irq_agg_chk #(
    parameter int SRC_W  = 18,
    parameter int DATA_W = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [SRC_W-1:0]           evt_i,
    input logic [hia_pkg::ADDR_W-1:0] addr_i,
    input logic                       wr_en_i,
    input logic [DATA_W-1:0]          wdata_i,
    input logic                       rd_en_i,
    input logic [SRC_W-1:0]           pend_q,
    input logic [SRC_W-1:0]           mask_q,
    input logic                       out_en_q,
    input logic                       act_low_q,
    input logic                       irq_o
);
    import hia_pkg::*;

    // R3: set alias leaves every written-1 bit set in the mask.
    p_mask_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_en_i && addr_i == A_MSET)
        |=> ((mask_q & $past(wdata_i[SRC_W-1:0])) == $past(wdata_i[SRC_W-1:0])));

    // R6: a take read leaves only the events of that same cycle pending.
    p_take_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && rd_en_i && addr_i == A_TAKE && !wr_en_i)
        |=> (pend_q == $past(evt_i)));

    // R7: acknowledged bits without a new event are cleared.
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_en_i && addr_i == A_ACK && !rd_en_i)
        |=> ((pend_q & $past(wdata_i[SRC_W-1:0]) & ~$past(evt_i)) == '0));

    // R8: every event pulse is pending on the next cycle.
    p_event_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && |evt_i)
        |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

    // R9: a disabled line rests at the selected inactive level.
    p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !out_en_q) |=> (irq_o == $past(act_low_q)));
endmodule

bind host_irq_agg host_irq_agg_chk #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wdata_i   (wdata_i),
    .rd_en_i   (rd_en_i),
    .pend_q    (pend_q),
    .mask_q    (mask_q),
    .out_en_q  (out_en_q),
    .act_low_q (act_low_q),
    .irq_o     (irq_o)
);

// File: tb/host_irq_agg_test.sv
// Scoreboard bench: the driver pushes expected read data from a register
// model, the monitor pops and compares when read data is presented.
module host_irq_agg_test;
    localparam int SRC_W  = 18;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [SRC_W-1:0]  evt = '0;
    logic [2:0]        addr = '0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wdata = '0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [SRC_W-1:0] mask_m = SRC_W'(1);
    logic [SRC_W-1:0] pend_m = '0;
    logic [1:0]       cfg_m  = 2'b00;

    logic [DATA_W-1:0] exp_q[$];
    string             tag_q[$];
    logic              rd_seen = 1'b0;

    always #10 clk = ~clk;

    host_irq_agg #(.SRC_W(SRC_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .addr_i(addr),
        .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en),
        .rd_data_o(rd_data), .irq_o(irq)
    );

    function automatic logic [DATA_W-1:0] model_read(input logic [2:0] a);
        case (a)
            3'd0:    return DATA_W'(mask_m);
            3'd3:    return DATA_W'(pend_m);
            3'd4:    return DATA_W'(pend_m);
            3'd6:    return DATA_W'(cfg_m);
            default: return '0;
        endcase
    endfunction

    task automatic compare(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp, input string tag);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // One bus cycle with optional write, read and event pulse.
    task automatic cycle(input bit w, input bit r, input logic [2:0] a,
                         input logic [DATA_W-1:0] d, input logic [SRC_W-1:0] e,
                         input string tag);
        if (r) begin
            exp_q.push_back(model_read(a));
            tag_q.push_back(tag);
        end
        wr_en = w; rd_en = r; addr = a; wdata = d; evt = e;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; evt = '0;
        if (r && a == 3'd4) pend_m = '0;
        if (w) begin
            case (a)
                3'd0: mask_m = d[SRC_W-1:0];
                3'd1: mask_m = mask_m | d[SRC_W-1:0];
                3'd2: mask_m = mask_m & ~d[SRC_W-1:0];
                3'd5: pend_m = pend_m & ~d[SRC_W-1:0];
                3'd6: cfg_m  = d[1:0];
                default: ;
            endcase
        end
        pend_m = pend_m | e;
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        cycle(1'b0, 1'b1, a, '0, '0, tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
        cycle(1'b1, 1'b0, a, d, '0, "");
    endtask

    task automatic fire(input logic [SRC_W-1:0] e);
        cycle(1'b0, 1'b0, 3'd0, '0, e, "");
    endtask

    // Line check one cycle after the state settles (output flop).
    task automatic check_irq(input string tag);
        logic exp;
        @(negedge clk);
        exp = (cfg_m[0] && |(pend_m & ~mask_m)) ^ cfg_m[1];
        compare(DATA_W'(irq), DATA_W'(exp), tag);
    endtask

    // Monitor: note read strobes at the edge, compare afterwards.
    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                compared++; mismatched++;
                $display("FAIL R10: actual read with no expected entry, expected none");
            end else begin
                compare(rd_data, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        compare(DATA_W'(irq), '0, "R1 irq after reset");
        rd(3'd0, "R1 mask reset");
        rd(3'd6, "R1 cfg reset");
        rd(3'd3, "R1 peek reset");
        rd(3'd4, "R1 take reset");
        // R2: direct write, high bits read 0
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, "R2 mask all ones");
        wr(3'd0, 32'h0000_0003);
        rd(3'd0, "R2 mask direct");
        // R3 / R4: aliases
        wr(3'd1, 32'h0000_0100);
        rd(3'd0, "R3 mask set alias");
        wr(3'd2, 32'h0000_0001);
        rd(3'd0, "R4 mask clear alias");
        // R5 / R11: non-destructive view, masked source still latches
        fire(18'h00401);
        rd(3'd3, "R5 peek first");
        rd(3'd3, "R5 peek second");
        fire(18'h00100);
        rd(3'd3, "R11 masked source latched");
        // R6: take clears all
        rd(3'd4, "R6 take returns pending");
        rd(3'd3, "R6 peek after take");
        // R7: selective acknowledge
        fire(18'h30021);
        wr(3'd5, 32'h0000_0021);
        rd(3'd3, "R7 after ack");
        // R8: event coincident with take and with ack
        cycle(1'b0, 1'b1, 3'd4, '0, 18'h10000, "R8 take with event");
        rd(3'd3, "R8 event survived take");
        cycle(1'b1, 1'b0, 3'd5, 32'h0001_0000, 18'h10000, "");
        rd(3'd3, "R8 event survived ack");
        // R10: write-only and spare addresses read zero
        rd(3'd1, "R10 set alias reads 0");
        rd(3'd2, "R10 clear alias reads 0");
        rd(3'd5, "R10 ack reads 0");
        rd(3'd7, "R10 spare reads 0");
        // R9: line behaviour
        fire(18'h00080);
        check_irq("R9 disabled active high");
        wr(3'd6, 32'h1);
        wr(3'd0, 32'h0003_FFFF);
        check_irq("R9 all masked");
        wr(3'd0, 32'h0);
        check_irq("R9 unmasked pending");
        wr(3'd6, 32'h3);
        check_irq("R9 active low asserted");
        rd(3'd4, "R9 drain pending");
        check_irq("R9 active low idle");
        wr(3'd6, 32'h2);
        check_irq("R9 disabled active low");
        rd(3'd6, "R9 cfg readback");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            compared++; mismatched++;
            $display("FAIL R10: actual %0d reads unanswered expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule